// File: doc/BRIEF.md
# Shared Memory Bus Arbiter with Refresh Scheduling

The block decides which of four masters owns a shared external memory bus. The masters are a display list processor, a signal processor, a graphics processor and a block-copy engine. It also decides when DRAM refresh cycles get the bus. Each master raises a request line and receives a one-hot grant. The current owner pulses `done_i` when its transfer ends, and the arbiter only re-arbitrates at that point or while the bus is idle.

A refresh timer pulses `refresh_due_i`, and each pulse adds one to a saturating count of owed refreshes. The display processor outranks pending refresh, so a refresh owed while it keeps requesting is held back. Once the display processor stops requesting, the refresh runs ahead of the other masters. If the owed count reaches a threshold, the arbiter forces back-to-back refresh cycles ahead of every master until nothing is owed.

The display processor can mark its request as releasable. The arbiter then gives the bus to one lower master between two of its transfers. Two boost inputs let the signal and graphics processors, or the block-copy engine, rise above the display processor.

Top module: `mem_bus_arbiter`

## Requirements
- R1: At most one of `gnt_o[3:0]` and `refresh_gnt_o` is high in any cycle. Grant bit 0 is the display processor, bit 1 the signal processor, bit 2 the graphics processor and bit 3 the block-copy engine.
- R2: The bus goes idle with all grants low when arbitration finds no request and no owed refresh. Arbitration happens while idle, or in a cycle with `done_i` high.
- R3: A grant, including a refresh grant, stays unchanged in every cycle where `done_i` is low. A new owner appears in the cycle after the arbitration edge.
- R4: With boosts and release low and no forced refresh, the priority is display, then signal, then graphics, then block-copy.
- R5: While the display processor requests and no refresh is forced, no refresh grant is issued, whatever the owed count.
- R6: When the display processor is not requesting, an owed refresh wins over the signal, graphics and block-copy processors.
- R7: When the owed count is at or above FORCE_AT (default 4), refresh wins over every master. Refresh grants then repeat at each arbitration until the owed count is zero, and only then does the display processor regain the bus.
- R8: With `release_i` high, if the display processor owned the last slot and an unboosted lower master requests, the highest such master gets one slot. The display processor then wins the next arbitration.
- R9: `boost_proc_i` raises the signal and graphics processors, and `boost_blit_i` raises the block-copy engine, above the display processor. The order among boosted masters is signal, graphics, block-copy.
- R10: The owed count saturates at OWED_MAX (default 7). Extra due pulses are lost, so a saturated forced burst is exactly OWED_MAX refresh grants long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Bus requests, bit 0 display, 1 signal, 2 graphics, 3 block-copy |
| release_i | input | 1 | Display processor's current request allows a lower master in |
| boost_proc_i | input | 1 | Raises the signal and graphics processors above the display processor |
| boost_blit_i | input | 1 | Raises the block-copy engine above the display processor |
| refresh_due_i | input | 1 | One-cycle pulse, one more refresh owed |
| done_i | input | 1 | Current owner's transfer or refresh ends this cycle |
| gnt_o | output | 4 | One-hot master grant |
| refresh_gnt_o | output | 1 | Bus is given to a refresh cycle |

## Verification
A wrong owed count or burst flag stays hidden until the next arbitration edge. It then appears as a refresh grant where a display grant was due, or the reverse, one cycle after `done_i`. A burst that is too short or too long is only visible by counting consecutive refresh grants, so the saturated-burst test counts them exactly. A bad owner register shows up at once, as two grants high together or a grant that changes while `done_i` is low.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NUM_MASTERS = 4;
  localparam int unsigned M_DISP = 0;
  localparam int unsigned M_SIG  = 1;
  localparam int unsigned M_GFX  = 2;
  localparam int unsigned M_BLIT = 3;

  typedef enum logic [2:0] {
    OWN_NONE,
    OWN_DISP,
    OWN_SIG,
    OWN_GFX,
    OWN_BLIT,
    OWN_REFR
  } owner_e;
endpackage

// File: rtl/arb_refresh_owed.sv
module arb_refresh_owed #(
  parameter int unsigned OWED_MAX = 7,
  parameter int unsigned FORCE_AT = 4,
  localparam int unsigned CW = $clog2(OWED_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due_i,
  input  logic take_i,
  output logic owed_nz_o,
  output logic force_o
);
  logic [CW-1:0] owed_q, owed_d;
  logic          burst_q, burst_d;
  logic          inc, dec;

  assign inc = due_i && (owed_q != CW'(OWED_MAX));
  assign dec = take_i && (owed_q != '0);

  always_comb begin
    owed_d = owed_q;
    if (inc && !dec)      owed_d = owed_q + 1'b1;
    else if (dec && !inc) owed_d = owed_q - 1'b1;
    burst_d = (owed_d != '0) && (burst_q || (owed_q >= CW'(FORCE_AT)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      if (inc != dec) owed_q <= owed_d;
      burst_q <= burst_d;
    end
  end

  assign owed_nz_o = (owed_q != '0);
  assign force_o   = burst_q || (owed_q >= CW'(FORCE_AT));

  p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= CW'(OWED_MAX));

  p_burst_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q >= CW'(FORCE_AT)) |=> (burst_q || (owed_q == '0)));
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
(
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic                   release_i,
  input  logic                   boost_proc_i,
  input  logic                   boost_blit_i,
  input  logic                   owed_nz_i,
  input  logic                   force_i,
  input  logic                   last_disp_i,
  output owner_e                 pick_o
);
  logic [NUM_MASTERS-1:0] low_free;

  always_comb begin
    low_free         = '0;
    low_free[M_SIG]  = req_i[M_SIG]  && !boost_proc_i;
    low_free[M_GFX]  = req_i[M_GFX]  && !boost_proc_i;
    low_free[M_BLIT] = req_i[M_BLIT] && !boost_blit_i;

    pick_o = OWN_NONE;
    if (force_i && owed_nz_i)               pick_o = OWN_REFR;
    else if (boost_proc_i && req_i[M_SIG])  pick_o = OWN_SIG;
    else if (boost_proc_i && req_i[M_GFX])  pick_o = OWN_GFX;
    else if (boost_blit_i && req_i[M_BLIT]) pick_o = OWN_BLIT;
    else if (req_i[M_DISP]) begin
      if (release_i && last_disp_i && (low_free != '0)) begin
        if (low_free[M_SIG])      pick_o = OWN_SIG;
        else if (low_free[M_GFX]) pick_o = OWN_GFX;
        else                      pick_o = OWN_BLIT;
      end else begin
        pick_o = OWN_DISP;
      end
    end
    else if (owed_nz_i)      pick_o = OWN_REFR;
    else if (req_i[M_SIG])   pick_o = OWN_SIG;
    else if (req_i[M_GFX])   pick_o = OWN_GFX;
    else if (req_i[M_BLIT])  pick_o = OWN_BLIT;
  end
endmodule

// File: rtl/mem_bus_arbiter.sv
module mem_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned OWED_MAX = 7,
  parameter int unsigned FORCE_AT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] req_i,
  input  logic       release_i,
  input  logic       boost_proc_i,
  input  logic       boost_blit_i,
  input  logic       refresh_due_i,
  input  logic       done_i,
  output logic [3:0] gnt_o,
  output logic       refresh_gnt_o
);
  owner_e owner_q, owner_d, pick;
  logic   arbitrate, owed_nz, force_ref, take_ref;

  assign arbitrate = (owner_q == OWN_NONE) || done_i;
  assign take_ref  = arbitrate && (pick == OWN_REFR);

  arb_refresh_owed #(.OWED_MAX(OWED_MAX), .FORCE_AT(FORCE_AT)) i_owed (
    .clk       (clk),
    .rst_n     (rst_n),
    .due_i     (refresh_due_i),
    .take_i    (take_ref),
    .owed_nz_o (owed_nz),
    .force_o   (force_ref)
  );

  arb_pick i_pick (
    .req_i        (req_i),
    .release_i    (release_i),
    .boost_proc_i (boost_proc_i),
    .boost_blit_i (boost_blit_i),
    .owed_nz_i    (owed_nz),
    .force_i      (force_ref),
    .last_disp_i  (owner_q == OWN_DISP),
    .pick_o       (pick)
  );

  always_comb begin
    owner_d = owner_q;
    if (arbitrate) owner_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         owner_q <= OWN_NONE;
    else if (arbitrate) owner_q <= owner_d;
  end

  always_comb begin
    gnt_o = '0;
    gnt_o[M_DISP] = (owner_q == OWN_DISP);
    gnt_o[M_SIG]  = (owner_q == OWN_SIG);
    gnt_o[M_GFX]  = (owner_q == OWN_GFX);
    gnt_o[M_BLIT] = (owner_q == OWN_BLIT);
  end
  assign refresh_gnt_o = (owner_q == OWN_REFR);

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_o, refresh_gnt_o}));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && ({gnt_o, refresh_gnt_o} != '0)) |=>
      $stable({gnt_o, refresh_gnt_o}));

  p_defer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arbitrate && req_i[M_DISP] && !force_ref) |=> !refresh_gnt_o);

  p_disp_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arbitrate && req_i[M_DISP] && !force_ref && !release_i &&
     !boost_proc_i && !boost_blit_i) |=> (gnt_o == 4'b0001));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arbitrate && (req_i == '0) && !owed_nz) |=>
      ({gnt_o, refresh_gnt_o} == '0));
endmodule

// File: tb/test_mem_bus_arbiter.sv
module test_mem_bus_arbiter;
  logic       clk, rst_n;
  logic [3:0] req;
  logic       rel, bproc, bblit, due, done;
  logic [3:0] gnt;
  logic       rgnt;
  int         checks, errors;
  logic       finished;

  mem_bus_arbiter i_mem_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .release_i(rel),
    .boost_proc_i(bproc), .boost_blit_i(bblit), .refresh_due_i(due),
    .done_i(done), .gnt_o(gnt), .refresh_gnt_o(rgnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // req[4] rel bproc bblit due done | gnt[4] refresh
  localparam int NV = 27;
  localparam logic [13:0] VEC [NV] = '{
    14'b0000_0_0_0_0_0_0000_0, // R2 idle
    14'b1110_0_0_0_0_0_0010_0, // R4 signal first
    14'b1110_0_0_0_0_0_0010_0, // R3 held without done
    14'b1111_0_0_0_0_1_0001_0, // R4 display top
    14'b1101_0_0_0_0_1_0001_0, // R4 display again
    14'b1101_1_0_0_0_1_0100_0, // R8 gap to graphics
    14'b1101_1_0_0_0_1_0001_0, // R8 display returns
    14'b1000_0_0_0_0_1_1000_0, // R4 block-copy alone
    14'b0000_0_0_0_0_1_0000_0, // R2 idle
    14'b0001_0_0_0_1_0_0001_0, // owed 1
    14'b0001_0_0_0_0_1_0001_0, // R5 deferred
    14'b0100_0_0_0_0_1_0000_1, // R6 refresh over graphics
    14'b0100_0_0_0_0_1_0100_0, // R6 graphics after
    14'b0000_0_0_0_0_1_0000_0, // R2 idle
    14'b0001_0_0_0_1_0_0001_0, // owed 1
    14'b0001_0_0_0_1_0_0001_0, // owed 2
    14'b0001_0_0_0_1_0_0001_0, // owed 3
    14'b0001_0_0_0_1_0_0001_0, // owed 4
    14'b0001_0_0_0_0_1_0000_1, // R7 forced
    14'b0001_0_0_0_0_1_0000_1, // R7 burst
    14'b0001_0_0_0_0_1_0000_1, // R7 burst
    14'b0001_0_0_0_0_1_0000_1, // R7 burst last
    14'b0001_0_0_0_0_1_0001_0, // R7 display back
    14'b0011_0_1_0_0_1_0010_0, // R9 boosted signal
    14'b1001_0_0_1_0_1_1000_0, // R9 boosted block-copy
    14'b1001_0_0_0_0_1_0001_0, // R9 unboosted
    14'b0000_0_0_0_0_1_0000_0  // R2 idle
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got gnt/ref %b expected %b", tag, act, exp);
    end
    if (!$onehot0(act)) begin
      errors++;
      $display("FAIL R1: grants %b not exclusive", act);
    end
  endtask

  task automatic drive(input logic [3:0] r, input logic rl, input logic bp,
                       input logic bb, input logic du, input logic dn);
    req = r; rel = rl; bproc = bp; bblit = bb; due = du; done = dn;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(4'b0000, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    finished = 1'b0;
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0;
    do_reset();
    check("R2 reset", {gnt, rgnt}, 5'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13:10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      @(negedge clk);
      check($sformatf("vector %0d", i), {gnt, rgnt}, VEC[i][4:0]);
    end

    // R10: nine due pulses saturate the count at seven
    do_reset();
    drive(4'b0001, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R4 display from idle", {gnt, rgnt}, 5'b00010);
    for (int i = 0; i < 9; i++) begin
      drive(4'b0001, 0, 0, 0, 1, 0);
      @(negedge clk);
    end
    check("R3 display held during dues", {gnt, rgnt}, 5'b00010);
    for (int i = 0; i < 7; i++) begin
      drive(4'b0001, 0, 0, 0, 0, 1);
      @(negedge clk);
      check($sformatf("R10 burst slot %0d", i), {gnt, rgnt}, 5'b00001);
    end
    drive(4'b0001, 0, 0, 0, 0, 1);
    @(negedge clk);
    check("R10 burst ends after seven", {gnt, rgnt}, 5'b00010);

    // R8: release with no lower request keeps display
    drive(4'b0001, 1, 0, 0, 0, 1);
    @(negedge clk);
    check("R8 no lower request", {gnt, rgnt}, 5'b00010);
    // R8: release with only a boosted lower master does not apply
    drive(4'b1001, 1, 0, 1, 0, 1);
    @(negedge clk);
    check("R9 boosted block-copy", {gnt, rgnt}, 5'b10000);

    // R3: refresh grant held without done
    do_reset();
    drive(4'b0000, 0, 0, 0, 1, 0);
    @(negedge clk);
    drive(4'b0110, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R6 refresh from idle", {gnt, rgnt}, 5'b00001);
    @(negedge clk);
    check("R3 refresh held", {gnt, rgnt}, 5'b00001);
    drive(4'b0110, 0, 0, 0, 0, 1);
    @(negedge clk);
    check("R4 signal over graphics", {gnt, rgnt}, 5'b00100);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule